// File: doc/BRIEF.md
# Temperature Alarm Event Generator

This block turns a stream of signed temperature samples into a single active-low event line. Software programs it through a small write port. There are three threshold registers: an upper alarm bound, a lower alarm bound and a critical trip point. A configuration register holds an enable bit, a mode selection, a hysteresis code and a clear action. A new sample is presented with a one-cycle valid strobe. The block compares each new sample against the three thresholds and updates one alarm flag per threshold. The event line is then driven from these flags according to the selected mode.

Interrupt mode latches the event on any fresh crossing and holds it until software clears it. Comparator mode makes the event follow the window comparison. Critical-only mode reacts only to the trip point. A critical condition overrides every mode. While it is present, the event is held asserted and software clears have no effect. Temperatures and thresholds are 11-bit two's-complement numbers with 0.25 °C per LSB.

Top module: `therm_alarm_top`

## Requirements
- R1: After reset the event output is high. Every register reads as zero, so the block is disabled, in interrupt mode, with zero hysteresis and zero thresholds. A sample taken afterwards without any register write leaves the output high.
- R2: In comparator mode (config bits [2:1] = 01) the event output is low while the upper flag or the lower flag is set. The upper flag sets when a sample is strictly greater than the upper bound. The lower flag sets when a sample is strictly less than the lower bound. The output returns high once both flags have released.
- R3: Hysteresis is selected by config bits [4:3]: code 00 = 0 LSB, 01 = 6 LSB, 10 = 12 LSB, 11 = 24 LSB. It applies only when a flag releases. The upper flag and the critical flag release when a sample is less than or equal to their threshold minus the hysteresis. The lower flag releases when a sample is greater than or equal to the lower bound plus the hysteresis.
- R4: In interrupt mode (config bits [2:1] = 00) a sample that newly sets any of the three flags latches the event low. The event stays low after the temperature returns inside the window, until software clears it.
- R5: Software clears the interrupt latch by writing the config register with bit [5] set. After a clear, the event asserts again only when a flag newly sets. A flag that stays set does not re-assert the event.
- R6: In critical-only mode (config bits [2:1] = 10) the event output is low only while the critical flag is set. The critical flag sets when a sample is strictly greater than the critical trip point. The upper and lower bounds have no effect on the output in this mode.
- R7: While the critical flag is set and the block is enabled, the event output is low in every mode. A clear written during that time leaves the interrupt latch set.
- R8: Flags change only on a cycle where the sample valid strobe is high. A change of the temperature input without the strobe leaves the output unchanged.
- R9: With config bit [0] (enable) low the event output is high whatever the flags are. The flags keep being evaluated while disabled. All comparisons are signed, so negative samples compare correctly.
- R10: Writes select a register by address: 0 = config, 1 = upper bound, 2 = lower bound, 3 = critical trip point, each taking write data [10:0]. Mode code 11 behaves as comparator mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new temperature sample |
| smp_temp | input | 11 | Signed temperature sample, 0.25 °C per LSB |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register select for the write |
| wr_data | input | 11 | Write data |
| evt_n | output | 1 | Active-low event output, idle high |

## Verification
The output is decoded from registered flags and a registered latch. A wrong flag, a wrong hysteresis release or a wrong latch therefore appears on evt_n right after the clock edge that took the sample or the write. The bench checks the output half a cycle after every edge. Hysteresis faults appear only on a sample that falls inside the hysteresis band, so the stimulus steps the temperature to just above and exactly onto each release point. Latch faults appear only after the temperature has gone back inside the window, or after a clear issued while a flag is still set, so both of those sequences are included.

// File: rtl/therm_alarm_pkg.sv
// Shared types and helpers for the temperature alarm event generator.
// Assumes 0.25 degC per temperature LSB when decoding hysteresis.
package therm_alarm_pkg;

    typedef enum logic [1:0] {
        MODE_LATCH = 2'b00,
        MODE_TRACK = 2'b01,
        MODE_CRIT  = 2'b10,
        MODE_TRACK2 = 2'b11
    } alarm_mode_e;

    typedef struct packed {
        logic        en;
        alarm_mode_e mode;
        logic [1:0]  hyst;
    } alarm_cfg_t;

    localparam int HYST_W = 5;

    // Hysteresis code to LSB count: 0, 1.5, 3 and 6 degC.
    function automatic logic [HYST_W-1:0] hyst_lsb(input logic [1:0] code);
        case (code)
            2'b00:   return 5'd0;
            2'b01:   return 5'd6;
            2'b10:   return 5'd12;
            default: return 5'd24;
        endcase
    endfunction

endpackage

// File: rtl/therm_alarm_regs.sv
// Register bank: config, upper, lower and critical thresholds.
// Assumes data width equals temperature width; config uses bits [5:0].
module therm_alarm_regs
    import therm_alarm_pkg::*;
#(
    parameter int TW = 11,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [TW-1:0] wr_data,
    output alarm_cfg_t    cfg,
    output logic [TW-1:0] thr_hi,
    output logic [TW-1:0] thr_lo,
    output logic [TW-1:0] thr_crit,
    output logic          clr_pulse
);
    localparam logic [AW-1:0] A_CFG  = AW'(0);
    localparam logic [AW-1:0] A_HI   = AW'(1);
    localparam logic [AW-1:0] A_LO   = AW'(2);
    localparam logic [AW-1:0] A_CRIT = AW'(3);
    localparam int CLR_BIT = 5;

    // Register storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            thr_hi   <= '0;
            thr_lo   <= '0;
            thr_crit <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CFG: begin
                    cfg.en   <= wr_data[0];
                    cfg.mode <= alarm_mode_e'(wr_data[2:1]);
                    cfg.hyst <= wr_data[4:3];
                end
                A_HI:    thr_hi   <= wr_data;
                A_LO:    thr_lo   <= wr_data;
                A_CRIT:  thr_crit <= wr_data;
                default: ;
            endcase
        end
    end

    // Clear action: a config write carrying the clear bit.
    always_comb clr_pulse = wr_en && (wr_addr == A_CFG) && wr_data[CLR_BIT];

endmodule

// File: rtl/therm_alarm_cmp.sv
// One threshold comparator with release hysteresis.
// HIGH_SIDE=1 flags samples above the threshold, 0 flags samples below it.
// Assumes the flag is only evaluated on the sample strobe.
module therm_alarm_cmp
    import therm_alarm_pkg::*;
#(
    parameter int TW = 11,
    parameter bit HIGH_SIDE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] thr,
    input  logic [1:0]    hyst,
    output logic          flag_q,
    output logic          flag_d
);
    localparam int WW = TW + 2;

    logic signed [WW-1:0] t_w, thr_w, h_w, rel_pt;
    logic set_c, rel_c;

    // Sign-extend operands so threshold +/- hysteresis cannot overflow.
    always_comb begin
        t_w   = {{2{temp[TW-1]}}, temp};
        thr_w = {{2{thr[TW-1]}}, thr};
        h_w   = {{(WW-HYST_W){1'b0}}, hyst_lsb(hyst)};
    end

    generate
        if (HIGH_SIDE) begin : g_high
            // Above-threshold detection, release at threshold minus hysteresis.
            always_comb begin
                rel_pt = thr_w - h_w;
                set_c  = t_w > thr_w;
                rel_c  = t_w <= rel_pt;
            end
        end else begin : g_low
            // Below-threshold detection, release at threshold plus hysteresis.
            always_comb begin
                rel_pt = thr_w + h_w;
                set_c  = t_w < thr_w;
                rel_c  = t_w >= rel_pt;
            end
        end
    endgenerate

    // Next flag value: only a strobed sample can move it.
    always_comb begin
        if (!smp_valid)  flag_d = flag_q;
        else if (flag_q) flag_d = !rel_c;
        else             flag_d = set_c;
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    // R8: no strobe, no flag movement.
    assert_flag_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(flag_q));

    generate
        if (HIGH_SIDE) begin : g_chk_high
            // R3: a high-side flag only releases at or below threshold minus hysteresis.
            assert_release_point_R3: assert property (@(posedge clk) disable iff (!rst_n)
                flag_q && smp_valid && (t_w > thr_w - h_w) |=> flag_q);
        end else begin : g_chk_low
            // R3: a low-side flag only releases at or above threshold plus hysteresis.
            assert_release_point_R3: assert property (@(posedge clk) disable iff (!rst_n)
                flag_q && smp_valid && (t_w < thr_w + h_w) |=> flag_q);
        end
    endgenerate

endmodule

// File: rtl/therm_alarm_evt.sv
// Event mode logic: interrupt latch, comparator tracking, critical override.
// Assumes flags and their next values come from the comparators.
module therm_alarm_evt
    import therm_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  alarm_cfg_t cfg,
    input  logic       smp_valid,
    input  logic       clr_pulse,
    input  logic       hi_q,
    input  logic       hi_d,
    input  logic       lo_q,
    input  logic       lo_d,
    input  logic       cr_q,
    input  logic       cr_d,
    output logic       evt_n
);
    logic latch_q, int_mode, fresh, active;

    // Interrupt mode qualifier and fresh-crossing detect.
    always_comb begin
        int_mode = cfg.en && (cfg.mode == MODE_LATCH);
        fresh    = smp_valid && ((hi_d && !hi_q) || (lo_d && !lo_q) || (cr_d && !cr_q));
    end

    // Interrupt latch: set on a fresh crossing, cleared by software unless critical.
    always_ff @(posedge clk) begin
        if (!rst_n)                   latch_q <= 1'b0;
        else if (!int_mode)           latch_q <= 1'b0;
        else if (fresh)               latch_q <= 1'b1;
        else if (clr_pulse && !cr_q)  latch_q <= 1'b0;
    end

    // Output decode per mode, with the critical override on top.
    always_comb begin
        if (!cfg.en)      active = 1'b0;
        else if (cr_q)    active = 1'b1;
        else begin
            case (cfg.mode)
                MODE_LATCH: active = latch_q;
                MODE_CRIT:  active = 1'b0;
                default:    active = hi_q || lo_q;
            endcase
        end
        evt_n = !active;
    end

    // R4: the latch only drops through a clear or by leaving interrupt mode.
    assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int_mode && latch_q && !clr_pulse |=> latch_q);

    // R7: a clear during a critical condition leaves the latch set.
    assert_crit_blocks_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_mode && latch_q && cr_q && clr_pulse |=> latch_q);

    // R9: a disabled block keeps the line idle.
    assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> evt_n);

endmodule

// File: rtl/therm_alarm_top.sv
// Temperature alarm event generator top: registers, three comparators, mode logic.
// Assumes one sample per smp_valid strobe; synchronous active-low reset.
module therm_alarm_top
    import therm_alarm_pkg::*;
#(
    parameter int TW = 11,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [TW-1:0] smp_temp,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [TW-1:0] wr_data,
    output logic          evt_n
);
    localparam int NCMP = 3;
    localparam bit [NCMP-1:0] SIDE = 3'b101; // crit, lo, hi

    alarm_cfg_t    cfg;
    logic [TW-1:0] thr_hi, thr_lo, thr_crit;
    logic          clr_pulse;
    logic [TW-1:0] thr_v [NCMP];
    logic [NCMP-1:0] fq, fd;

    therm_alarm_regs #(.TW(TW), .AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg(cfg), .thr_hi(thr_hi), .thr_lo(thr_lo), .thr_crit(thr_crit),
        .clr_pulse(clr_pulse)
    );

    // Threshold routing to the comparator array.
    always_comb begin
        thr_v[0] = thr_hi;
        thr_v[1] = thr_lo;
        thr_v[2] = thr_crit;
    end

    generate
        for (genvar i = 0; i < NCMP; i++) begin : g_cmp
            therm_alarm_cmp #(.TW(TW), .HIGH_SIDE(SIDE[i])) cmp_i (
                .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .temp(smp_temp),
                .thr(thr_v[i]), .hyst(cfg.hyst), .flag_q(fq[i]), .flag_d(fd[i])
            );
        end
    endgenerate

    therm_alarm_evt evt_i (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .smp_valid(smp_valid), .clr_pulse(clr_pulse),
        .hi_q(fq[0]), .hi_d(fd[0]), .lo_q(fq[1]), .lo_d(fd[1]),
        .cr_q(fq[2]), .cr_d(fd[2]), .evt_n(evt_n)
    );

    // R1: the line is idle in the cycle after reset.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> evt_n);

endmodule

// File: tb/therm_alarm_top_tb_top.sv
// Vector-table bench for therm_alarm_top, then directed reset checks.
module therm_alarm_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 11;
    localparam int NV = 47;
    // Vector: [19:18] op (0 write, 1 strobed sample, 2 temp change without strobe),
    // [17:16] addr, [15:5] data, [4] expected evt_n, [3:0] requirement number.
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 2'd1, 11'd100,   1'b1, 4'd10}, // R10 upper=100
        {2'd0, 2'd2, 11'd0,     1'b1, 4'd10}, // R10 lower=0
        {2'd0, 2'd3, 11'd200,   1'b1, 4'd10}, // R10 crit=200
        {2'd0, 2'd0, 11'h00B,   1'b1, 4'd2},  // R2 comparator, hyst 6
        {2'd1, 2'd0, 11'd50,    1'b1, 4'd2},  // R2 inside
        {2'd1, 2'd0, 11'd101,   1'b0, 4'd2},  // R2 above upper
        {2'd1, 2'd0, 11'd97,    1'b0, 4'd3},  // R3 in band
        {2'd1, 2'd0, 11'd94,    1'b1, 4'd3},  // R3 release point
        {2'd1, 2'd0, 11'h7FF,   1'b0, 4'd9},  // R9 -1 below lower
        {2'd1, 2'd0, 11'd5,     1'b0, 4'd3},  // R3 low band
        {2'd1, 2'd0, 11'd6,     1'b1, 4'd3},  // R3 low release
        {2'd2, 2'd0, 11'd150,   1'b1, 4'd8},  // R8 no strobe
        {2'd1, 2'd0, 11'd150,   1'b0, 4'd8},  // R8 strobed
        {2'd1, 2'd0, 11'd50,    1'b1, 4'd2},  // R2 back inside
        {2'd0, 2'd0, 11'h009,   1'b1, 4'd4},  // R4 interrupt mode
        {2'd1, 2'd0, 11'd120,   1'b0, 4'd4},  // R4 crossing
        {2'd1, 2'd0, 11'd50,    1'b0, 4'd4},  // R4 held
        {2'd0, 2'd0, 11'h029,   1'b1, 4'd5},  // R5 clear
        {2'd1, 2'd0, 11'd120,   1'b0, 4'd5},  // R5 new crossing
        {2'd0, 2'd0, 11'h029,   1'b1, 4'd5},  // R5 clear while above
        {2'd1, 2'd0, 11'd130,   1'b1, 4'd5},  // R5 no fresh crossing
        {2'd1, 2'd0, 11'd50,    1'b1, 4'd5},  // R5 release
        {2'd1, 2'd0, 11'd110,   1'b0, 4'd5},  // R5 fresh crossing
        {2'd0, 2'd0, 11'h029,   1'b1, 4'd5},  // R5 clear
        {2'd1, 2'd0, 11'd210,   1'b0, 4'd7},  // R7 critical
        {2'd0, 2'd0, 11'h029,   1'b0, 4'd7},  // R7 clear ignored
        {2'd1, 2'd0, 11'd198,   1'b0, 4'd7},  // R7 crit in band
        {2'd1, 2'd0, 11'd50,    1'b0, 4'd7},  // R7 latch kept
        {2'd0, 2'd0, 11'h029,   1'b1, 4'd4},  // R4 clear
        {2'd0, 2'd0, 11'h005,   1'b1, 4'd6},  // R6 crit-only, hyst 0
        {2'd1, 2'd0, 11'd150,   1'b1, 4'd6},  // R6 upper ignored
        {2'd1, 2'd0, 11'h7EC,   1'b1, 4'd6},  // R6 -20 lower ignored
        {2'd1, 2'd0, 11'd201,   1'b0, 4'd6},  // R6 above crit
        {2'd1, 2'd0, 11'd200,   1'b1, 4'd3},  // R3 zero hysteresis
        {2'd0, 2'd0, 11'h004,   1'b1, 4'd9},  // R9 disabled
        {2'd1, 2'd0, 11'd300,   1'b1, 4'd9},  // R9 still idle
        {2'd0, 2'd0, 11'h003,   1'b0, 4'd9},  // R9 flags kept evaluating
        {2'd0, 2'd0, 11'h01B,   1'b0, 4'd3},  // R3 hyst 24
        {2'd1, 2'd0, 11'd177,   1'b0, 4'd3},  // R3 crit band
        {2'd1, 2'd0, 11'd77,    1'b0, 4'd3},  // R3 upper band
        {2'd1, 2'd0, 11'd76,    1'b1, 4'd3},  // R3 release at 76
        {2'd0, 2'd0, 11'h013,   1'b1, 4'd3},  // R3 hyst 12
        {2'd1, 2'd0, 11'h7FF,   1'b0, 4'd3},  // R3 below lower
        {2'd1, 2'd0, 11'd11,    1'b0, 4'd3},  // R3 low band
        {2'd1, 2'd0, 11'd12,    1'b1, 4'd3},  // R3 release at 12
        {2'd0, 2'd0, 11'h007,   1'b1, 4'd10}, // R10 mode 11
        {2'd1, 2'd0, 11'd101,   1'b0, 4'd10}  // R10 tracks
    };

    logic clk = 1'b0, rst_n = 1'b0, smp_valid = 1'b0, wr_en = 1'b0;
    logic [TW-1:0] smp_temp = '0, wr_data = '0;
    logic [1:0] wr_addr = '0;
    logic evt_n;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    therm_alarm_top #(.TW(TW), .AW(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .evt_n(evt_n)
    );

    task automatic check(input logic exp, input int req);
        n_chk++;
        if (evt_n !== exp) begin
            n_bad++;
            $display("FAIL R%0d: evt_n=%b expected %b at %0t", req, evt_n, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b1, 1); // R1 idle during reset
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b1, 1); // R1 idle after reset
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][19:18])
                2'd0: begin
                    wr_en = 1'b1; wr_addr = VEC[i][17:16]; wr_data = VEC[i][15:5];
                end
                2'd1: begin
                    smp_valid = 1'b1; smp_temp = VEC[i][15:5];
                end
                default: smp_temp = VEC[i][15:5];
            endcase
            @(posedge clk);
            @(negedge clk);
            wr_en = 1'b0; smp_valid = 1'b0;
            check(VEC[i][4], int'(VEC[i][3:0]));
        end
        // R1: reset mid-run returns to idle and disables the block.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b1, 1); // R1
        smp_valid = 1'b1; smp_temp = 11'd300;
        @(negedge clk);
        smp_valid = 1'b0;
        check(1'b1, 1); // R1 registers zero: still disabled
        finish_run();
    end
endmodule